// File: doc/BRIEF.md
# Per-Load Stride Prefetch Predictor

This block watches the stream of load instructions and learns, separately for each load, whether it walks memory with a constant step. A small direct-mapped table is indexed by the low bits of the load's program counter; each entry keeps the remaining program-counter bits as a tag, the address that load used last time, the step it is believed to take, and a two-bit confidence state. Each load updates its entry. The entry issues a prefetch request for the next expected address once it has seen the step repeat.

The confidence state has four values: fresh, transient, steady and unpredictable. A correct guess is one where the new address equals the stored address plus the stored step. A correct guess moves the entry towards steady. A wrong guess moves it away from steady, and on some of these transitions the step is relearned from the latest difference. A prefetch request appears one cycle after the load that caused it. The cache and the prefetch buffer that act on the request are outside this block.

Top module: `stride_prefetch_predictor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pf_valid` is 0 after that edge, and every table entry becomes empty.
- R2: A load whose index selects an empty entry, or an entry with a different tag, replaces that entry with the load's tag, its address, a step of zero and state fresh. It raises no prefetch.
- R3: A correct guess in state fresh or transient moves the entry to steady and keeps the step. A correct guess in steady stays in steady. Each of these raises a prefetch.
- R4: A wrong guess in state fresh moves the entry to transient. A wrong guess in transient moves it to unpredictable. Both store the new difference (current address minus stored address) as the step.
- R5: A wrong guess in steady moves the entry to fresh and keeps the old step. It raises no prefetch.
- R6: In state unpredictable, a correct guess moves the entry to transient and a wrong guess stays and stores the new difference as the step. Neither raises a prefetch.
- R7: A prefetch is raised only when the entry is steady after its update. It appears as `pf_valid`=1 in the cycle after the load, with `pf_addr` equal to the load address plus the entry's step.
- R8: The entry index is `ld_pc[IDX_W-1:0]` and the tag is the remaining upper bits. Two loads that share an index but have different tags evict each other.
- R9: Every load that hits its entry overwrites the stored address with its own address, so the next guess is based on that address.
- R10: A cycle with `ld_valid` low raises no prefetch in the next cycle. Steps are signed and address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| pf_valid | output | 1 | Prefetch request, registered |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The assertions assume that reset is held low from time zero until after the first clock edge. They also assume that `ld_pc` and `ld_addr` carry known values whenever `ld_valid` is high. The bench drives every input on the falling edge and holds `rst_n` low from time zero for several cycles. During idle cycles it keeps `ld_valid` low, so the table is read only with defined operands. The directed sequences visit every state transition, including a negative step that wraps and an index alias. A random phase then mixes steady walks with jumps.

// File: rtl/spp_pkg.sv
`timescale 1ns/1ps
// Shared types for the stride prefetch predictor.
// Assumes: a 2-bit confidence state per table entry.
package spp_pkg;
    typedef enum logic [1:0] {
        CONF_FRESH  = 2'd0,
        CONF_TRANS  = 2'd1,
        CONF_STEADY = 2'd2,
        CONF_NOPRED = 2'd3
    } conf_state_e;
endpackage

// File: rtl/spp_pc_split.sv
`timescale 1ns/1ps
// Splits a load program counter into a table index (low bits) and a tag
// (remaining upper bits). Assumes IDX_W < PC_W.
module spp_pc_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    // Purpose: pure field extraction, no state.
    assign idx = pc[IDX_W-1:0];
    assign tag = pc[PC_W-1:IDX_W];
endmodule

// File: rtl/spp_table.sv
`timescale 1ns/1ps
// Direct-mapped predictor storage: valid, tag, previous address, step
// and confidence per entry. One combinational read port, one write
// port. Assumes read and write share the same index in a cycle.
module spp_table
    import spp_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 28,
    parameter int ADDR_W = 32,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_state_e       rd_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_state_e       wr_state
);
    logic              valid_q  [ENTRIES];
    logic [TAG_W-1:0]  tag_q    [ENTRIES];
    logic [ADDR_W-1:0] prev_q   [ENTRIES];
    logic [ADDR_W-1:0] stride_q [ENTRIES];
    conf_state_e       state_q  [ENTRIES];

    // Purpose: clear all entries on reset, else write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                valid_q[e]  <= 1'b0;
                tag_q[e]    <= '0;
                prev_q[e]   <= '0;
                stride_q[e] <= '0;
                state_q[e]  <= CONF_FRESH;
            end
        end else if (wr_en) begin
            valid_q[wr_idx]  <= 1'b1;
            tag_q[wr_idx]    <= wr_tag;
            prev_q[wr_idx]   <= wr_prev;
            stride_q[wr_idx] <= wr_stride;
            state_q[wr_idx]  <= wr_state;
        end
    end

    // Purpose: asynchronous read of the addressed entry.
    always_comb begin
        rd_valid  = valid_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_prev   = prev_q[rd_idx];
        rd_stride = stride_q[rd_idx];
        rd_state  = state_q[rd_idx];
    end
endmodule

// File: rtl/spp_update.sv
`timescale 1ns/1ps
// Next-entry logic: checks the guess, picks the next confidence state
// and step, and decides whether to prefetch. Assumes two's-complement
// wrap-around arithmetic on ADDR_W-bit addresses.
module spp_update
    import spp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] rd_prev,
    input  logic [ADDR_W-1:0] rd_stride,
    input  conf_state_e       rd_state,
    output logic              guess_ok,
    output conf_state_e       nxt_state,
    output logic [ADDR_W-1:0] nxt_stride,
    output logic              issue
);
    logic [ADDR_W-1:0] guess;
    logic [ADDR_W-1:0] diff;

    // Purpose: form the guessed address and the newly observed difference.
    assign guess    = rd_prev + rd_stride;
    assign diff     = cur_addr - rd_prev;
    assign guess_ok = hit && (cur_addr == guess);

    // Purpose: confidence transition table with selective step relearning.
    always_comb begin
        nxt_state  = CONF_FRESH;
        nxt_stride = '0;
        if (hit) begin
            nxt_stride = rd_stride;
            unique case (rd_state)
                CONF_FRESH: begin
                    if (guess_ok) nxt_state = CONF_STEADY;
                    else begin
                        nxt_state  = CONF_TRANS;
                        nxt_stride = diff;
                    end
                end
                CONF_TRANS: begin
                    if (guess_ok) nxt_state = CONF_STEADY;
                    else begin
                        nxt_state  = CONF_NOPRED;
                        nxt_stride = diff;
                    end
                end
                CONF_STEADY: begin
                    nxt_state = guess_ok ? CONF_STEADY : CONF_FRESH;
                end
                CONF_NOPRED: begin
                    if (guess_ok) nxt_state = CONF_TRANS;
                    else begin
                        nxt_state  = CONF_NOPRED;
                        nxt_stride = diff;
                    end
                end
                default: nxt_state = CONF_FRESH;
            endcase
        end
    end

    // Purpose: only an entry that lands in steady requests a prefetch.
    assign issue = hit && (nxt_state == CONF_STEADY);
endmodule

// File: rtl/stride_prefetch_predictor.sv
`timescale 1ns/1ps
// Per-load stride prefetch predictor top. Each valid load reads its
// entry, updates it in the same cycle and registers a prefetch
// request for the next cycle. Assumes at most one load per cycle.
module stride_prefetch_predictor
    import spp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = PC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_prev;
    logic [ADDR_W-1:0] rd_stride;
    conf_state_e       rd_state;
    logic              hit;
    logic              pred_ok;
    conf_state_e       nxt_state;
    logic [ADDR_W-1:0] nxt_stride;
    logic              issue;

    spp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split (
        .pc  (ld_pc),
        .idx (idx),
        .tag (tag)
    );

    spp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_prev   (rd_prev),
        .rd_stride (rd_stride),
        .rd_state  (rd_state),
        .wr_en     (ld_valid),
        .wr_idx    (idx),
        .wr_tag    (tag),
        .wr_prev   (ld_addr),
        .wr_stride (nxt_stride),
        .wr_state  (nxt_state)
    );

    // Purpose: a hit needs a live entry with a matching tag.
    assign hit = rd_valid && (rd_tag == tag);

    spp_update #(.ADDR_W(ADDR_W)) u_update (
        .hit        (hit),
        .cur_addr   (ld_addr),
        .rd_prev    (rd_prev),
        .rd_stride  (rd_stride),
        .rd_state   (rd_state),
        .guess_ok   (pred_ok),
        .nxt_state  (nxt_state),
        .nxt_stride (nxt_stride),
        .issue      (issue)
    );

    // Purpose: register the prefetch request one cycle after its load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= ld_valid && issue;
            pf_addr  <= ld_addr + nxt_stride;
        end
    end
endmodule

// File: rtl/spp_checker.sv
`timescale 1ns/1ps
// Property checker for the stride prefetch predictor, bound to the top.
// Assumes reset is low from time zero until after the first edge.
module spp_checker
    import spp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              hit,
    input conf_state_e       rd_state,
    input logic [ADDR_W-1:0] rd_stride,
    input logic              correct,
    input logic [ADDR_W-1:0] upd_stride
);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !pf_valid);

    p_miss_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !hit) |=> !pf_valid);

    p_pf_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit) |=> (!pf_valid || pf_addr == $past(ld_addr) + $past(upd_stride)));

    p_fresh_ok_pf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && rd_state == CONF_FRESH && correct) |=> pf_valid);

    p_steady_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && rd_state == CONF_STEADY) |-> upd_stride == rd_stride);

    p_steady_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && rd_state == CONF_STEADY && !correct) |=> !pf_valid);

    p_nopred_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && rd_state == CONF_NOPRED) |=> !pf_valid);
endmodule

bind stride_prefetch_predictor spp_checker #(.ADDR_W(ADDR_W)) u_spp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_addr    (ld_addr),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr),
    .hit        (hit),
    .rd_state   (rd_state),
    .rd_stride  (rd_stride),
    .correct    (pred_ok),
    .upd_stride (nxt_stride)
);

// File: tb/stride_prefetch_predictor_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes the expected prefetch from a
// requirement-level model and queues it; the monitor compares.
module stride_prefetch_predictor_bench;
    localparam int PC_W = 32;
    localparam int AW   = 32;
    localparam int IW   = 4;
    localparam int NENT = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [PC_W-1:0] ld_pc = '0;
    logic [AW-1:0] ld_addr = '0;
    logic          pf_valid;
    logic [AW-1:0] pf_addr;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic          v;
        logic [AW-1:0] a;
        string         req;
    } exp_t;
    exp_t sb[$];

    // Model: 0 fresh, 1 transient, 2 steady, 3 unpredictable.
    logic          m_valid [NENT];
    logic [PC_W-IW-1:0] m_tag [NENT];
    logic [AW-1:0] m_prev  [NENT];
    logic [AW-1:0] m_step  [NENT];
    int            m_st    [NENT];

    always #10 clk = ~clk;  // 50 MHz

    stride_prefetch_predictor #(.PC_W(PC_W), .ADDR_W(AW), .IDX_W(IW)) u_stride_prefetch_predictor (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic model_clear;
        for (int e = 0; e < NENT; e++) begin
            m_valid[e] = 1'b0; m_tag[e] = '0; m_prev[e] = '0; m_step[e] = '0; m_st[e] = 0;
        end
    endtask

    // Driver: one load on the falling edge, expected result queued.
    task automatic do_load(input logic [PC_W-1:0] pc, input logic [AW-1:0] addr, input string req);
        int i;
        logic ok;
        exp_t x;
        @(negedge clk);
        ld_valid = 1'b1; ld_pc = pc; ld_addr = addr;
        i = int'(pc[IW-1:0]);
        x.v = 1'b0; x.a = '0; x.req = req;
        if (!m_valid[i] || m_tag[i] != pc[PC_W-1:IW]) begin
            m_valid[i] = 1'b1; m_tag[i] = pc[PC_W-1:IW]; m_step[i] = '0; m_st[i] = 0;
        end else begin
            ok = (addr == m_prev[i] + m_step[i]);
            case (m_st[i])
                0: if (ok) m_st[i] = 2; else begin m_st[i] = 1; m_step[i] = addr - m_prev[i]; end
                1: if (ok) m_st[i] = 2; else begin m_st[i] = 3; m_step[i] = addr - m_prev[i]; end
                2: if (!ok) m_st[i] = 0;
                default: if (ok) m_st[i] = 1; else m_step[i] = addr - m_prev[i];
            endcase
            if (m_st[i] == 2) begin x.v = 1'b1; x.a = addr + m_step[i]; end
        end
        m_prev[i] = addr;
        sb.push_back(x);
    endtask

    task automatic do_idle(input string req);
        exp_t x;
        @(negedge clk);
        ld_valid = 1'b0; ld_pc = '0; ld_addr = '0;
        x.v = 1'b0; x.a = '0; x.req = req;
        sb.push_back(x);
    endtask

    // Monitor: compare each registered result shortly after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                checks++;
                if (pf_valid !== x.v || (x.v && pf_addr !== x.a)) begin
                    fails++;
                    $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
                             x.req, pf_valid, pf_addr, x.v, x.a);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
        $finish;
    end

    localparam logic [31:0] PA = 32'h0000_1001;  // index 1
    localparam logic [31:0] PB = 32'h0000_1002;
    localparam logic [31:0] PC3 = 32'h0000_1003;
    localparam logic [31:0] PD = 32'h0000_1004;
    localparam logic [31:0] PE = 32'h0000_1006;
    localparam logic [31:0] PALIAS = 32'h0000_2001;  // index 1, other tag

    initial begin
        logic [31:0] pcs [6];
        logic [31:0] base [6];
        logic [31:0] stp [6];
        model_clear();
        repeat (4) @(negedge clk);
        // R1: output quiet while held in reset.
        checks++;
        if (pf_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: pf_valid=%0b expected 0", pf_valid);
        end
        rst_n = 1'b1;

        // R2, R3, R7, R9: allocate, learn +8, reach steady, stay.
        do_load(PA, 32'h0000_4000, "R2");
        do_load(PA, 32'h0000_4008, "R4");
        do_load(PA, 32'h0000_4010, "R3");
        do_load(PA, 32'h0000_4018, "R7");
        // R5: wrong guess in steady -> fresh, step kept.
        do_load(PA, 32'h0000_4064, "R5");
        do_load(PA, 32'h0000_406C, "R9");
        do_idle("R10");

        // R4, R6: transient -> unpredictable -> transient -> steady.
        do_load(PB, 32'h0001_0000, "R2");
        do_load(PB, 32'h0001_0004, "R4");
        do_load(PB, 32'h0001_0014, "R4");
        do_load(PB, 32'h0001_0024, "R6");
        do_load(PB, 32'h0001_0034, "R3");

        // R6: unpredictable wrong guess stays and relearns.
        do_load(PC3, 32'h0002_0000, "R2");
        do_load(PC3, 32'h0002_0004, "R4");
        do_load(PC3, 32'h0002_000A, "R4");
        do_load(PC3, 32'h0002_001E, "R6");
        do_load(PC3, 32'h0002_0032, "R6");
        do_load(PC3, 32'h0002_0046, "R3");

        // R10: negative step wrapping below zero.
        do_load(PD, 32'h0000_0010, "R2");
        do_idle("R10");
        do_load(PD, 32'h0000_0008, "R4");
        do_load(PD, 32'h0000_0000, "R10");

        // R3: zero step, repeated address is a correct guess.
        do_load(PE, 32'h0003_0000, "R2");
        do_load(PE, 32'h0003_0000, "R3");

        // R8: alias on index 1 evicts the entry, then the original misses.
        do_load(PALIAS, 32'h0000_4074, "R8");
        do_load(PA, 32'h0000_4074, "R8");
        do_load(PA, 32'h0000_407C, "R8");

        // R1: reset mid-run empties the table.
        @(negedge clk);
        ld_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        sb.delete();
        model_clear();
        do_load(PE, 32'h0003_0000, "R1");
        do_load(PE, 32'h0003_0000, "R3");

        // Random mix of walks and jumps.
        pcs[0] = PA; pcs[1] = PB; pcs[2] = PC3; pcs[3] = PD; pcs[4] = PE; pcs[5] = PALIAS;
        for (int k = 0; k < 6; k++) begin
            base[k] = $urandom; stp[k] = 32'($urandom_range(0, 64)) - 32'd32;
        end
        for (int n = 0; n < 600; n++) begin
            int k;
            k = $urandom_range(0, 5);
            if ($urandom_range(0, 7) == 0) stp[k] = 32'($urandom_range(0, 64)) - 32'd32;
            if ($urandom_range(0, 11) == 0) base[k] = $urandom;
            else base[k] = base[k] + stp[k];
            if ($urandom_range(0, 9) == 0) do_idle("R10");
            else do_load(pcs[k], base[k], "R7");
        end
        do_idle("R10");
        do_idle("R10");
        @(negedge clk);
        report();
        $finish;
    end
endmodule